// File: doc/BRIEF.md
# Legacy System Control Port

This block is a single byte-wide register on a plain legacy host I/O bus. It answers at one I/O address, 0x92, and is one byte wide. Two of its bits reach the rest of the chip. Bit 1 drives the gate for address line 20. A 0-to-1 change of bit 0 produces a one-cycle request to the system reset controller. Software can read back all eight bits.

The block has two separate resets. The power-on reset clears the whole register. The device reset clears only the reset-request bit and keeps the gate setting and the other six bits. A bus cycle is one clock wide. `ioWr` and `ioRd` act as strobes that are qualified by the address. Only single-byte transfers exist.

Top module: `sys_ctl_port`

## Requirements
- R1: While `rst` is high at a rising edge, the register becomes 0x00 and `a20Gate` and `resetReq` become 0.
- R2: A write (`ioWr` high, `ioAddr` equal to 0x92) stores all 8 bits of `ioWdata` at that rising edge.
- R3: `ioRdata` is combinational. It shows the stored byte while `ioRd` is high and `ioAddr` is 0x92, and it is 0x00 at any other time.
- R4: A write or read at any address other than 0x92 changes neither the register, `a20Gate` nor `resetReq`.
- R5: `a20Gate` is a register. It takes bit 1 of the new register value at the same edge that stores a write, and it holds between writes.
- R6: `resetReq` goes high for exactly one cycle after the edge that stores a write with bit 0 = 1 while the stored bit 0 was 0.
- R7: A write with bit 0 = 1 while the stored bit 0 is already 1 raises no request, and neither does a write with bit 0 = 0.
- R8: `devRst` high at an edge clears bit 0 of the register and leaves bits 7..1 and `a20Gate` unchanged.
- R9: When `devRst` and a write fall in the same edge, bits 7..1 come from the write, bit 0 ends as 0, and no request is raised.
- R10: After a device reset has cleared bit 0, a write with bit 0 = 1 raises the request again.
- R11: A read in the same cycle as a write returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset, clears the whole register |
| devRst | input | 1 | Synchronous active-high device reset, clears bit 0 only |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Write strobe, one cycle per access |
| ioRd | input | 1 | Read strobe, one cycle per access |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, zero when the port is not selected for a read |
| a20Gate | output | 1 | Address-line-20 gate, registered copy of bit 1 |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
Two of the block's functions can land on the same edge. One is the device reset that clears bit 0. The other is a host write that could set bit 0. The bench forces this collision by asserting `devRst` together with every write data value, starting from stored bytes with bit 0 both clear and set. It then checks three results: the request stays low, bits 7..1 come from the write, and bit 0 reads back as zero. A second collision, a read in the same cycle as a write, is judged by requiring the old byte on `ioRdata`.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;

  // Strobes the decode stage hands to the register datapath.
  typedef struct packed {
    logic pwrClr;   // power-on clear of the whole register
    logic devClr;   // device reset: clear the request bit only
    logic wrHit;    // write addressed to this port
    logic rdHit;    // read addressed to this port
  } ctlStrobe_t;

endpackage

// File: rtl/sys_ctl_decode.sv
module sys_ctl_decode
  import sys_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0092
) (
  input  logic              rst,
  input  logic              devRst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  output ctlStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

  logic addrHit;

  assign addrHit = (ioAddr == MATCH);

  always_comb begin
    strobe        = '0;
    strobe.pwrClr = rst;
    // Power-on reset dominates every other strobe.
    strobe.devClr = devRst & ~rst;
    strobe.wrHit  = ioWr & addrHit & ~rst;
    strobe.rdHit  = ioRd & addrHit;
  end

endmodule

// File: rtl/sys_ctl_regs.sv
module sys_ctl_regs
  import sys_ctl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GATE_BIT = 1,
  parameter int RST_BIT  = 0
) (
  input  logic              clk,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData,
  output logic              gateOut,
  output logic              reqOut
);

  logic [DATA_W-1:0] regQ;
  logic [DATA_W-1:0] regNext;
  logic              reqNext;

  // Next register value: a write loads everything, device reset then
  // forces the request bit low.
  always_comb begin
    regNext = regQ;
    if (strobe.wrHit) regNext = wData;
    if (strobe.devClr) regNext[RST_BIT] = 1'b0;
  end

  // Request on a 0->1 change of the request bit, not during device reset.
  assign reqNext = strobe.wrHit & wData[RST_BIT] & ~regQ[RST_BIT] & ~strobe.devClr;

  always_ff @(posedge clk) begin
    if (strobe.pwrClr) begin
      regQ    <= '0;
      gateOut <= 1'b0;
      reqOut  <= 1'b0;
    end else begin
      regQ    <= regNext;
      gateOut <= regNext[GATE_BIT];
      reqOut  <= reqNext;
    end
  end

  // Read data gated bit by bit by the read select.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    assign rData[i] = regQ[i] & strobe.rdHit;
  end

endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import sys_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0092,
  parameter int          GATE_BIT  = 1,
  parameter int          RST_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              devRst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              a20Gate,
  output logic              resetReq
);

  ctlStrobe_t strobe;

  sys_ctl_decode #(
    .ADDR_W   (ADDR_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .rst   (rst),
    .devRst(devRst),
    .ioAddr(ioAddr),
    .ioWr  (ioWr),
    .ioRd  (ioRd),
    .strobe(strobe)
  );

  sys_ctl_regs #(
    .DATA_W  (DATA_W),
    .GATE_BIT(GATE_BIT),
    .RST_BIT (RST_BIT)
  ) u_regs (
    .clk    (clk),
    .strobe (strobe),
    .wData  (ioWdata),
    .rData  (ioRdata),
    .gateOut(a20Gate),
    .reqOut (resetReq)
  );

endmodule

// File: rtl/sys_ctl_port_chk.sv
module sys_ctl_port_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0092,
  parameter int          GATE_BIT  = 1,
  parameter int          RST_BIT   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              devRst,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioWdata,
  input logic [DATA_W-1:0] ioRdata,
  input logic              a20Gate,
  input logic              resetReq
);

  logic wrSel;
  logic rdSel;

  assign wrSel = ioWr && (ioAddr == ADDR_W'(PORT_ADDR));
  assign rdSel = ioRd && (ioAddr == ADDR_W'(PORT_ADDR));

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> !resetReq); // R6
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> $past(wrSel && ioWdata[RST_BIT] && !devRst)); // R6
  AST_REQ_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (wrSel && rdSel && ioRdata[RST_BIT]) |=> !resetReq); // R7
  AST_GATE_TRACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrSel)) |-> (a20Gate == $past(ioWdata[GATE_BIT]))); // R5
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrSel)) |-> $stable(a20Gate)); // R8
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rdSel |-> (ioRdata == '0)); // R3
  AST_DEVRST_NOREQ: assert property (@(posedge clk) disable iff (rst)
    $past(devRst) |-> !resetReq); // R9

endmodule

bind sys_ctl_port sys_ctl_port_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PORT_ADDR(PORT_ADDR),
  .GATE_BIT (GATE_BIT),
  .RST_BIT  (RST_BIT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .devRst  (devRst),
  .ioAddr  (ioAddr),
  .ioWr    (ioWr),
  .ioRd    (ioRd),
  .ioWdata (ioWdata),
  .ioRdata (ioRdata),
  .a20Gate (a20Gate),
  .resetReq(resetReq)
);

// File: tb/sys_ctl_port_bench.sv
module sys_ctl_port_bench;

  localparam logic [15:0] PORT = 16'h0092;

  logic        clk = 1'b0;
  logic        rst;
  logic        devRst;
  logic [15:0] ioAddr;
  logic        ioWr;
  logic        ioRd;
  logic [7:0]  ioWdata;
  logic [7:0]  ioRdata;
  logic        a20Gate;
  logic        resetReq;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] model;

  always #2 clk = ~clk;

  sys_ctl_port u_sys_ctl_port (
    .clk(clk), .rst(rst), .devRst(devRst), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .a20Gate(a20Gate), .resetReq(resetReq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    ioWr = 1'b0; ioRd = 1'b0; devRst = 1'b0; ioAddr = 16'h0000; ioWdata = 8'h00;
  endtask

  // Read at addr; expected value follows R3.
  task automatic readAt(input logic [15:0] addr, input logic [7:0] exp, input string req);
    @(negedge clk);
    idleBus();
    ioRd = 1'b1; ioAddr = addr;
    #1 chk(req, ioRdata, exp);
    @(negedge clk);
    idleBus();
  endtask

  // Write v (with optional device reset in the same cycle) and check
  // request, gate, readback and pulse end.
  task automatic writeChk(input logic [7:0] v, input logic dev, input string req);
    logic expReq;
    logic [7:0] oldVal;
    oldVal = model;
    expReq = v[0] & ~model[0] & ~dev;
    model  = dev ? {v[7:1], 1'b0} : v;
    @(negedge clk);
    idleBus();
    ioWr = 1'b1; ioRd = 1'b1; ioAddr = PORT; ioWdata = v; devRst = dev;
    #1 chk("R11 read during write", ioRdata, oldVal);
    @(negedge clk);
    chk({req, " request"}, {7'b0, resetReq}, {7'b0, expReq});
    chk("R5 gate", {7'b0, a20Gate}, {7'b0, model[1]});
    idleBus();
    ioRd = 1'b1; ioAddr = PORT;
    #1 chk(dev ? "R9 readback" : "R2 readback", ioRdata, model);
    @(negedge clk);
    chk("R6 pulse width", {7'b0, resetReq}, 8'h00);
    idleBus();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idleBus();
    rst = 1'b1;
    model = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 gate", {7'b0, a20Gate}, 8'h00);
    chk("R1 request", {7'b0, resetReq}, 8'h00);
    rst = 1'b0;
    readAt(PORT, 8'h00, "R1 register");

    // Sweep every data value from four start states (bits 1:0 varied).
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 256; v++) begin
        writeChk(8'(p) | 8'hA4, 1'b0, "R2 setup");
        writeChk(8'(v), 1'b0, (p[0] && v[0]) ? "R7" : "R6");
      end
    end

    // Device reset alone: clears bit 0 only, gate held.
    for (int v = 0; v < 256; v++) begin
      writeChk(8'(v), 1'b0, "R2 setup");
      @(negedge clk);
      devRst = 1'b1;
      @(negedge clk);
      idleBus();
      model[0] = 1'b0;
      chk("R8 gate held", {7'b0, a20Gate}, {7'b0, model[1]});
      chk("R8 no request", {7'b0, resetReq}, 8'h00);
      readAt(PORT, model, "R8 register");
      if (v[0]) writeChk(8'(v), 1'b0, "R10");
    end

    // Collision of device reset with a write, from both bit-0 states.
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        writeChk(8'(p), 1'b0, "R2 setup");
        writeChk(8'(v), 1'b1, "R9");
      end
    end

    // Off-address accesses: nothing changes, reads return zero.
    writeChk(8'h02, 1'b0, "R2 setup");
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a;
      a = PORT ^ (16'h0001 << k);
      @(negedge clk);
      idleBus();
      ioWr = 1'b1; ioAddr = a; ioWdata = 8'hFF;
      @(negedge clk);
      chk("R4 no request", {7'b0, resetReq}, 8'h00);
      chk("R4 gate", {7'b0, a20Gate}, 8'h01);
      idleBus();
      readAt(a, 8'h00, "R3 off-address read");
      readAt(PORT, model, "R4 register");
    end
    readAt(PORT, 8'h02, "R3 select");
    @(negedge clk);
    chk("R3 idle data", ioRdata, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule